// File: doc/BRIEF.md
# NAND Hamming Parity Generator

This block sits beside a NAND flash data path and builds a single-error-correct, double-error-detect Hamming code over one block of data (512 bytes by default). Data arrives as a valid/ready stream of beats. Each beat carries either one byte or two bytes, depending on the column mode. Every data bit has an address, which is its byte index times eight plus its bit index. For each address bit the block keeps two running parities: the "even" parity of all bits whose address bit is 0, and the "odd" parity of all bits whose address bit is 1. For a 512-byte block this gives twelve pairs, spanning from the bit-level parity up to the half-block parity.

Software arms the block with a one-cycle clear pulse. The pulse zeroes the parities and the byte count, and it captures the block length and the column mode. The engine then takes beats while it is enabled until the programmed number of bytes has been consumed. After that it raises a done flag and stops accepting data. The result appears as a 32-bit word, with the even parities in the low half and the odd parities starting at bit 16. It also appears as three packed code bytes ready to be stored in the spare area. The code is not inverted, so an erased (all-0xFF) block yields an all-zero code.

Back-pressure: a beat is taken only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low while the engine is disabled, once the block is complete, and in a cycle where clear is asserted. The upstream source holds its beat until it is taken.

Top module: `nand_hamming_ecc`

## Requirements
- R1: After reset, `result` and `code` are zero, `done` is low, and `in_ready` follows `en` (low while `en` is low).
- R2: For a bit at address A = byte_index*8 + bit_index, result bit b (0..11) is the XOR of all data bits with A[b]=0, and result bit 16+b is the XOR of all data bits with A[b]=1. Bits 12..15 and 28..31 read zero.
- R3: `code[7:0]` equals result[7:0], `code[15:8]` equals result[23:16], and `code[23:16]` equals {result[27:24], result[11:8]}.
- R4: In 8-bit column mode (`wide`=0 at clear), each accepted beat is one byte taken from `in_data[7:0]`. `in_data[15:8]` has no effect.
- R5: In 16-bit column mode (`wide`=1 at clear), each accepted beat is two bytes: `in_data[7:0]` at the current byte index and `in_data[15:8]` at the next index.
- R6: With `size_m1` captured at clear, the block is 2*(`size_m1`+1) bytes. `done` rises in the cycle after the beat carrying the last byte is accepted. From then until the next clear, `done` stays high and `in_ready` stays low.
- R7: While `en` is low, `in_ready` is low and presented beats leave `result` and `done` unchanged.
- R8: A clear pulse zeroes the result, the byte count and `done` by the next cycle. A beat presented in the same cycle as clear is not accepted and does not count toward the block.
- R9: A block of all-0xFF bytes yields `code` = 0x000000, which differs from the erased spare contents.
- R10: `result` changes only in a cycle that follows an accepted beat or a clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | One-cycle clear/arm pulse; also captures `size_m1` and `wide` |
| en | input | 1 | Engine enable |
| wide | input | 1 | Column mode: 1 = 16-bit beats, 0 = 8-bit beats |
| size_m1 | input | 8 | Block length in 16-bit units minus one |
| in_valid | input | 1 | Data beat valid |
| in_ready | output | 1 | Block can take a beat this cycle |
| in_data | input | 16 | Data beat (low byte first in 16-bit mode) |
| done | output | 1 | Block fully consumed |
| result | output | 32 | Even parities in [11:0], odd parities in [27:16] |
| code | output | 24 | Three packed ECC bytes |

## Verification
Clear and data intake can fall in the same cycle, and clear must win. The bench first feeds part of a block. It then raises `clr` together with a valid beat, and at that point `in_ready` must already be low. In the next cycle the result and `done` must be zero. The bench then feeds a complete block from index zero and checks that `done` rises exactly after the final beat and that the code matches the model. A discarded beat that was counted would make both checks fail. The same approach covers the engine being disabled, and a beat offered after `done`, in the middle of a stream.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

  localparam int RES_W   = 32;
  localparam int ODD_LSB = 16;
  localparam int CODE_W  = 24;

  typedef enum logic {
    COL8  = 1'b0,
    COL16 = 1'b1
  } col_mode_e;

  // Mask of bit positions j within a byte whose index bit b equals zero.
  function automatic logic [7:0] low_half_mask(input int b);
    logic [7:0] m;
    for (int j = 0; j < 8; j++) m[j] = ((j >> b) & 1) == 0;
    return m;
  endfunction

  // Spare-area byte order: low even, low odd, then high nibbles paired.
  function automatic logic [CODE_W-1:0] pack_code(input logic [RES_W-1:0] r);
    return {r[27:24], r[11:8], r[23:16], r[7:0]};
  endfunction

endpackage

// File: rtl/ecc_byte_parity.sv
// Contribution of one byte at a given byte index to the even/odd parity pairs.
module ecc_byte_parity #(
  parameter int IDX_W  = 9,
  parameter int ADDR_W = IDX_W + 3
) (
  input  logic [7:0]        din,
  input  logic [IDX_W-1:0]  idx,
  input  logic              live,
  output logic [ADDR_W-1:0] ev,
  output logic [ADDR_W-1:0] od
);
  import ecc_pkg::*;

  logic byte_par;
  assign byte_par = ^din;

  for (genvar b = 0; b < ADDR_W; b++) begin : g_pair
    if (b < 3) begin : g_col
      localparam logic [7:0] M0 = low_half_mask(b);
      assign ev[b] = live & (^(din & M0));
      assign od[b] = live & (^(din & ~M0));
    end else begin : g_row
      assign ev[b] = live & byte_par & ~idx[b-3];
      assign od[b] = live & byte_par &  idx[b-3];
    end
  end

endmodule

// File: rtl/ecc_block_counter.sv
// Counts consumed bytes against the captured block length and flags completion.
module ecc_block_counter #(
  parameter int CNT_W = 10,
  parameter int SZ_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic             two_bytes,
  input  logic [SZ_W-1:0]  size_m1,
  output logic [CNT_W-1:0] count,
  output logic             done
);

  logic [CNT_W-1:0] total;
  logic [CNT_W-1:0] step;
  logic [CNT_W-1:0] count_nxt;

  assign total     = (CNT_W'(size_m1) + CNT_W'(1)) << 1;
  assign step      = two_bytes ? CNT_W'(2) : CNT_W'(1);
  assign count_nxt = count + step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      done  <= 1'b0;
    end else if (clr) begin
      count <= '0;
      done  <= 1'b0;
    end else if (take) begin
      count <= count_nxt;
      done  <= (count_nxt == total);
    end
  end

endmodule

// File: rtl/ecc_parity_accum.sv
// Running even/odd parity registers.
module ecc_parity_accum #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic [ADDR_W-1:0] ev_in,
  input  logic [ADDR_W-1:0] od_in,
  output logic [ADDR_W-1:0] ev_q,
  output logic [ADDR_W-1:0] od_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q <= '0;
      od_q <= '0;
    end else if (clr) begin
      ev_q <= '0;
      od_q <= '0;
    end else if (take) begin
      ev_q <= ev_q ^ ev_in;
      od_q <= od_q ^ od_in;
    end
  end

endmodule

// File: rtl/nand_hamming_ecc.sv
module nand_hamming_ecc #(
  parameter int MAX_BYTES = 512,
  parameter int LANES     = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic        wide,
  input  logic [7:0]  size_m1,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [15:0] in_data,
  output logic        done,
  output logic [31:0] result,
  output logic [23:0] code
);
  import ecc_pkg::*;

  localparam int IDX_W  = $clog2(MAX_BYTES);
  localparam int ADDR_W = IDX_W + 3;
  localparam int CNT_W  = IDX_W + 1;
  localparam int SZ_W   = IDX_W - 1;

  col_mode_e        mode_q;
  logic [SZ_W-1:0]  size_q;
  logic             take;
  logic [CNT_W-1:0] count;
  logic [ADDR_W-1:0] ev_q, od_q;
  logic [ADDR_W-1:0] lane_ev [LANES];
  logic [ADDR_W-1:0] lane_od [LANES];
  logic [ADDR_W-1:0] ev_sum, od_sum;

  // Mode and length are captured on the arming pulse.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= COL8;
      size_q <= '1;
    end else if (clr) begin
      mode_q <= col_mode_e'(wide);
      size_q <= size_m1[SZ_W-1:0];
    end
  end

  assign in_ready = en & ~done & ~clr;
  assign take     = in_valid & in_ready;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [IDX_W-1:0] lane_idx;
    logic             lane_live;
    assign lane_idx  = count[IDX_W-1:0] + IDX_W'(l);
    assign lane_live = (l == 0) ? 1'b1 : (mode_q == COL16);
    ecc_byte_parity #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_bp (
      .din  (in_data[8*l +: 8]),
      .idx  (lane_idx),
      .live (lane_live),
      .ev   (lane_ev[l]),
      .od   (lane_od[l])
    );
  end

  always_comb begin
    ev_sum = '0;
    od_sum = '0;
    for (int l = 0; l < LANES; l++) begin
      ev_sum = ev_sum ^ lane_ev[l];
      od_sum = od_sum ^ lane_od[l];
    end
  end

  ecc_parity_accum #(.ADDR_W(ADDR_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .take  (take),
    .ev_in (ev_sum),
    .od_in (od_sum),
    .ev_q  (ev_q),
    .od_q  (od_q)
  );

  ecc_block_counter #(.CNT_W(CNT_W), .SZ_W(SZ_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .take      (take),
    .two_bytes (mode_q == COL16),
    .size_m1   (size_q),
    .count     (count),
    .done      (done)
  );

  always_comb begin
    result = '0;
    result[ADDR_W-1:0]        = ev_q;
    result[ODD_LSB +: ADDR_W] = od_q;
  end

  assign code = pack_code(result);

endmodule

// File: rtl/nand_hamming_ecc_chk.sv
module nand_hamming_ecc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        clr,
  input logic        en,
  input logic        in_valid,
  input logic        in_ready,
  input logic        done,
  input logic [31:0] result
);

  // R7
  ready_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !in_ready);

  // R6
  done_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);

  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> done);

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (result == 32'h0 && !done));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_ready) && !clr) |=> $stable(result));

endmodule

bind nand_hamming_ecc nand_hamming_ecc_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr      (clr),
  .en       (en),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .done     (done),
  .result   (result)
);

// File: tb/nand_hamming_ecc_tb.sv
module nand_hamming_ecc_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        en = 1'b0;
  logic        wide = 1'b0;
  logic [7:0]  size_m1 = 8'd0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = 16'h0;
  logic        done;
  logic [31:0] result;
  logic [23:0] code;

  int checks = 0;
  int errors = 0;
  logic [7:0] mem [512];

  always #10 clk = ~clk;

  nand_hamming_ecc u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .wide(wide),
    .size_m1(size_m1), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .done(done), .result(result), .code(code)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input int n);
    logic [31:0] r = '0;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < 8; j++)
        if (mem[i][j])
          for (int b = 0; b < 12; b++)
            if (((i * 8 + j) >> b) & 1) r[16 + b] = ~r[16 + b];
            else r[b] = ~r[b];
    return r;
  endfunction

  function automatic logic [23:0] packm(input logic [31:0] r);
    return {r[27:24], r[11:8], r[23:16], r[7:0]};
  endfunction

  task automatic arm(input int nbytes, input bit w);
    @(negedge clk);
    size_m1 = 8'(nbytes / 2 - 1);
    wide = w;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  // Feeds bytes [from, to) of mem; called at a negedge, returns at a negedge.
  task automatic feed(input int from, input int to, input bit w);
    int k = from;
    while (k < to) begin
      in_valid = 1'b1;
      if (w) begin
        in_data = {mem[k + 1], mem[k]};
        k += 2;
      end else begin
        in_data = {8'(k * 37 + 5), mem[k]};
        k += 1;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic check_block(input int n, input string req);
    logic [31:0] e = model(n);
    chk(result == e, req, result, e);
    chk(code == packm(e), "R3 code packing", {8'h0, code}, {8'h0, packm(e)});
    chk(done === 1'b1, "R6 done after last beat", {31'h0, done}, 32'h1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(result == 0 && done == 0, "R1 reset state", result, 32'h0);
    chk(in_ready == 1'b0, "R1 ready with en low", {31'h0, in_ready}, 32'h0);
    en = 1'b1;
    #1 chk(in_ready == 1'b1, "R1 ready with en high", {31'h0, in_ready}, 32'h1);

    // R2/R5 single-bit sweep over a 32-byte block, both column modes, closed form.
    for (int w = 0; w < 2; w++)
      for (int a = 0; a < 256; a++) begin
        logic [31:0] e;
        for (int i = 0; i < 32; i++) mem[i] = 8'h0;
        mem[a / 8][a % 8] = 1'b1;
        e = {4'h0, 12'(a), 4'h0, ~12'(a)};
        arm(32, w[0]);
        feed(0, 32, w[0]);
        chk(result == e, w ? "R5 single bit 16-bit" : "R2 single bit 8-bit", result, e);
      end

    // Full 512-byte blocks, several patterns, both modes.
    for (int p = 0; p < 3; p++)
      for (int w = 0; w < 2; w++) begin
        for (int i = 0; i < 512; i++)
          mem[i] = (p == 0) ? 8'(i * 7 + 3) : (p == 1) ? 8'(i ^ (i >> 3)) : 8'(i * i + 91);
        arm(512, w[0]);
        feed(0, 510, w[0]);
        chk(done == 1'b0, "R6 done low before last byte", {31'h0, done}, 32'h0);
        feed(510, 512, w[0]);
        check_block(512, w ? "R5 full block 16-bit" : "R4 full block 8-bit");
      end

    // R9 erased block.
    for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
    arm(512, 1'b0);
    feed(0, 512, 1'b0);
    chk(code == 24'h0, "R9 erased code zero", {8'h0, code}, 32'h0);
    chk(code != 24'hFFFFFF, "R9 differs from spare", {8'h0, code}, 32'hFFFFFF);

    // R6 beat after done has no effect.
    snap = result;
    in_valid = 1'b1; in_data = 16'h1234;
    #1 chk(in_ready == 1'b0, "R6 ready low when done", {31'h0, in_ready}, 32'h0);
    @(negedge clk); in_valid = 1'b0;
    chk(result == snap, "R6 result held after done", result, snap);

    // Size sweep: block lengths 2..64 bytes, both modes.
    for (int s = 0; s < 32; s++)
      for (int w = 0; w < 2; w++) begin
        int n = 2 * (s + 1);
        for (int i = 0; i < n; i++) mem[i] = 8'(i * 29 + s * 3 + w);
        arm(n, w[0]);
        feed(0, n - (w ? 2 : 1), w[0]);
        chk(done == 1'b0, "R6 done low early", {31'h0, done}, 32'h0);
        feed(n - (w ? 2 : 1), n, w[0]);
        check_block(n, "R6 size sweep");
      end

    // R7 disabled mid-block.
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 11 + 1);
    arm(64, 1'b0);
    feed(0, 20, 1'b0);
    snap = result;
    en = 1'b0;
    in_valid = 1'b1; in_data = 16'h00FF;
    #1 chk(in_ready == 1'b0, "R7 ready low when disabled", {31'h0, in_ready}, 32'h0);
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    chk(result == snap, "R7 result unchanged while disabled", result, snap);
    chk(done == 1'b0, "R7 done unchanged while disabled", {31'h0, done}, 32'h0);
    en = 1'b1;
    feed(20, 64, 1'b0);
    check_block(64, "R7 block after re-enable");

    // R8 clear and beat in the same cycle.
    for (int w = 0; w < 2; w++) begin
      for (int i = 0; i < 40; i++) mem[i] = 8'(i * 53 + 17);
      arm(40, w[0]);
      feed(0, 12, w[0]);
      clr = 1'b1; in_valid = 1'b1; in_data = 16'hA55A;
      #1 chk(in_ready == 1'b0, "R8 ready low during clear", {31'h0, in_ready}, 32'h0);
      @(negedge clk);
      clr = 1'b0; in_valid = 1'b0;
      chk(result == 0 && done == 0, "R8 cleared state", result, 32'h0);
      feed(0, 38, w[0]);
      chk(done == 1'b0, "R8 beat at clear not counted", {31'h0, done}, 32'h0);
      feed(38, 40, w[0]);
      check_block(40, "R8 block after clear");
    end

    // R10 idle hold.
    snap = result;
    repeat (5) @(negedge clk);
    chk(result == snap, "R10 idle hold", result, snap);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule